// File: doc/BRIEF.md
# Banked 32-bit Byte-Masked Memory Bus

This block sits between a 32-bit processor core and its local address space. A 16-bit byte address is split into four 16 KB banks by its two top bits: a low RAM, a ROM, a window passed through to peripheral registers, and a high RAM. Each RAM and the ROM hold 4 KB, so inside a memory bank only the word index taken from the low 12 address bits selects a location, and the 4 KB image repeats through the rest of the bank.

The bus is natively one word wide. A 4-bit byte mask decides which byte lanes a write updates, so narrow stores never need a read-modify-write or repeated byte cycles. Reads always return the full aligned word. The CPU's sign or zero extension of narrow loads is handled elsewhere. The ROM cannot be written, and its content is computed from the word index. Every request, read or write, is answered by a ready pulse one clock later, with the read data present in that same cycle.

Top module: `mbus_router`

## Requirements
- R1: The bank is chosen by address bits [15:14]: 0 selects the low RAM, 1 the ROM, 2 the peripheral window and 3 the high RAM. The two RAMs are separate storage.
- R2: `cpu_ready` is high in the cycle after every cycle in which `cpu_rd` or `cpu_wr` is high, and low after every cycle with neither strobe.
- R3: A read returns, together with its ready pulse, the full word at the addressed location. Address bits [1:0] are ignored.
- R4: On a RAM write, mask bit i writes data bits [8i+7:8i]. Bytes whose mask bit is 0 keep their earlier value.
- R5: Within a RAM bank only address bits [11:2] index the storage, so addresses that differ only in bits [13:12] or [1:0] reach the same word.
- R6: Writes to the ROM bank change nothing. The ROM word at index i = addr[11:2] reads as {~i16, i16}, where i16 is i zero-extended to 16 bits.
- R7: For the peripheral bank, `per_rd` and `per_wr` follow the CPU strobes in the same cycle. `per_addr` is addr[13:0], and the write data and mask pass through unchanged. `per_rdata`, sampled in the request cycle, is returned one cycle later. Outside that bank both peripheral strobes stay low.
- R8: `cpu_rdata` is zero whenever `cpu_ready` is low, and also on the ready pulse of a write.
- R9: If `cpu_rd` and `cpu_wr` are high together, the request is a write only.
- R10: While reset is applied and right after it, `cpu_ready` is low and `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Byte address from the CPU |
| cpu_wdata | input | 32 | Write data |
| cpu_mask | input | 4 | Byte lane write mask |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 32 | Aligned read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 14 | Offset inside the peripheral window |
| per_wdata | output | 32 | Peripheral write data |
| per_mask | output | 4 | Peripheral byte mask |
| per_rdata | input | 32 | Peripheral read data |

## Verification
The embedded assertions watch, on every cycle, the request-to-ready timing, the zero read data outside read completions, the blocking of write enables in the ROM bank, that peripheral strobes appear only inside their window, and that no two bank enables are active at once. Storage effects cannot be shown by a per-cycle property. These are byte-lane merging, aliasing of the upper index bits, independence of the two RAMs and the ROM content after a write attempt. The bench shows them by comparing every read against its own model of memory after directed and random mixes of masked writes and reads.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    BANK_RAM_LO = 2'd0,
    BANK_ROM    = 2'd1,
    BANK_PERIPH = 2'd2,
    BANK_RAM_HI = 2'd3
  } bank_e;

  // ROM image: upper half is the inverted index, lower half the index.
  function automatic logic [WORD_W-1:0] rom_word(input logic [15:0] idx);
    return {~idx, idx};
  endfunction

  // Merge new bytes into an old word under a lane mask.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  mask);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = mask[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_bits,
  input  logic       rd,
  input  logic       wr,
  output bank_e      bank,
  output logic       ram_lo_rd,
  output logic       ram_lo_we,
  output logic       ram_hi_rd,
  output logic       ram_hi_we,
  output logic       rom_rd,
  output logic       per_rd,
  output logic       per_wr
);
  logic is_rd, is_wr;

  assign bank  = bank_e'(bank_bits);
  assign is_wr = wr;           // write wins when both strobes are high (R9)
  assign is_rd = rd & ~wr;

  assign ram_lo_rd = is_rd & (bank == BANK_RAM_LO);
  assign ram_lo_we = is_wr & (bank == BANK_RAM_LO);
  assign ram_hi_rd = is_rd & (bank == BANK_RAM_HI);
  assign ram_hi_we = is_wr & (bank == BANK_RAM_HI);
  assign rom_rd    = is_rd & (bank == BANK_ROM);
  assign per_rd    = is_rd & (bank == BANK_PERIPH);
  assign per_wr    = is_wr & (bank == BANK_PERIPH);

  // R6: a write aimed at the ROM bank enables no storage anywhere
  a_r6_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank_bits == 2'd1) |-> !(ram_lo_we || ram_hi_we || per_wr));

  // R1: at most one bank is touched per cycle
  a_r1_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_lo_rd, ram_lo_we, ram_hi_rd, ram_hi_we, rom_rd, per_rd, per_wr}));
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram
  import mbus_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rd,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  mask,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && mask[g]) lane_mem[idx] <= wdata[8*g +: 8];
    end
    assign rd_word[8*g +: 8] = lane_mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rd) rdata <= rd_word;
  end
endmodule

// File: rtl/mbus_rom.sv
module mbus_rom
  import mbus_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rd) rdata <= rom_word(16'(idx));
  end
endmodule

// File: rtl/mbus_router.sv
module mbus_router
  import mbus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MEM_BYTES = 4096,
  localparam int unsigned WORDS    = MEM_BYTES / LANES,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned IDX_LSB  = $clog2(LANES),
  localparam int unsigned WIN_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_mask,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic              per_rd,
  output logic              per_wr,
  output logic [WIN_W-1:0]  per_addr,
  output logic [31:0]       per_wdata,
  output logic [3:0]        per_mask,
  input  logic [31:0]       per_rdata
);
  bank_e             bank, bank_q;
  logic              ram_lo_rd, ram_lo_we, ram_hi_rd, ram_hi_we, rom_rd;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] ram_lo_q, ram_hi_q, rom_q, per_q;
  logic              req_q, rd_q;

  assign word_idx  = cpu_addr[IDX_LSB +: IDX_W];
  assign per_addr  = cpu_addr[WIN_W-1:0];
  assign per_wdata = cpu_wdata;
  assign per_mask  = cpu_mask;

  mbus_decode u_decode (
    .clk(clk), .rst_n(rst_n), .bank_bits(cpu_addr[ADDR_W-1 -: 2]),
    .rd(cpu_rd), .wr(cpu_wr), .bank(bank),
    .ram_lo_rd(ram_lo_rd), .ram_lo_we(ram_lo_we),
    .ram_hi_rd(ram_hi_rd), .ram_hi_we(ram_hi_we),
    .rom_rd(rom_rd), .per_rd(per_rd), .per_wr(per_wr)
  );

  mbus_ram #(.WORDS(WORDS)) u_ram_lo (
    .clk(clk), .rd(ram_lo_rd), .we(ram_lo_we), .idx(word_idx),
    .wdata(cpu_wdata), .mask(cpu_mask), .rdata(ram_lo_q)
  );

  mbus_ram #(.WORDS(WORDS)) u_ram_hi (
    .clk(clk), .rd(ram_hi_rd), .we(ram_hi_we), .idx(word_idx),
    .wdata(cpu_wdata), .mask(cpu_mask), .rdata(ram_hi_q)
  );

  mbus_rom #(.WORDS(WORDS)) u_rom (
    .clk(clk), .rd(rom_rd), .idx(word_idx), .rdata(rom_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      rd_q   <= 1'b0;
      bank_q <= BANK_RAM_LO;
      per_q  <= '0;
    end else begin
      req_q <= cpu_rd | cpu_wr;
      rd_q  <= cpu_rd & ~cpu_wr;
      if (cpu_rd && !cpu_wr) bank_q <= bank;
      if (per_rd) per_q <= per_rdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (rd_q) begin
      unique case (bank_q)
        BANK_RAM_LO: cpu_rdata = ram_lo_q;
        BANK_ROM:    cpu_rdata = rom_q;
        BANK_PERIPH: cpu_rdata = per_q;
        BANK_RAM_HI: cpu_rdata = ram_hi_q;
      endcase
    end
  end
  assign cpu_ready = req_q;

  // R2: every request is acknowledged exactly one cycle later
  a_r2_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd || cpu_wr) |=> cpu_ready);
  a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |=> !cpu_ready);

  // R8: read data stays zero unless a read is completing
  a_r8_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> cpu_rdata == '0);
  a_r8_write_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> cpu_rdata == '0);

  // R7: peripheral strobes only inside the peripheral window
  a_r7_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd || per_wr) |-> cpu_addr[ADDR_W-1 -: 2] == 2'd2);

  // R7: peripheral read data is returned one cycle after its request
  a_r7_per_return: assert property (@(posedge clk) disable iff (!rst_n)
    per_rd |=> cpu_rdata == $past(per_rdata));
endmodule

// File: tb/mbus_router_tb.sv
`timescale 1ns/1ps
module mbus_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_mask = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        per_rd, per_wr;
  logic [13:0] per_addr;
  logic [31:0] per_wdata;
  logic [3:0]  per_mask;
  logic [31:0] per_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdl_lo [1024];
  logic [31:0] mdl_hi [1024];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] per_resp(input logic [13:0] a);
    return {2'b10, a, a ^ 14'h2AAA, 2'b01};
  endfunction
  assign per_rdata = per_resp(per_addr);

  function automatic logic [31:0] exp_rom(input logic [9:0] i);
    logic [15:0] w;
    w = {6'd0, i};
    return {~w, w};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] m);
    logic [31:0] byte_sel;
    byte_sel = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    return (n & byte_sel) | (o & ~byte_sel);
  endfunction

  mbus_router u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_mask(cpu_mask), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_mask(per_mask), .per_rdata(per_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request: drive at a falling edge, sample the acknowledge one cycle later.
  task automatic op(input bit rd, input bit wr, input logic [15:0] a,
                    input logic [31:0] d, input logic [3:0] m,
                    output logic [31:0] rdat, output bit rdy,
                    output bit p_rd, output bit p_wr);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_mask = m;
    #1;
    p_rd = per_rd; p_wr = per_wr;
    if (a[15:14] == 2'd2 && (rd || wr)) begin
      chk(per_addr == a[13:0], "R7 per_addr", {18'd0, per_addr}, {18'd0, a[13:0]});
      chk(per_wdata == d && per_mask == m, "R7 passthrough", per_wdata, d);
    end
    @(negedge clk);
    rdy = cpu_ready; rdat = cpu_rdata;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  // Full checked request against the bench model.
  task automatic run(input bit rd, input bit wr, input logic [15:0] a,
                     input logic [31:0] d, input logic [3:0] m, input string tag);
    logic [31:0] rdat, exp;
    bit rdy, prd, pwr, is_w;
    logic [9:0] i;
    i = a[11:2];
    is_w = wr;
    exp = '0;
    if (!is_w) begin
      case (a[15:14])
        2'd0: exp = mdl_lo[i];
        2'd1: exp = exp_rom(i);
        2'd2: exp = per_resp(a[13:0]);
        default: exp = mdl_hi[i];
      endcase
    end else begin
      if (a[15:14] == 2'd0) mdl_lo[i] = merge(mdl_lo[i], d, m);
      if (a[15:14] == 2'd3) mdl_hi[i] = merge(mdl_hi[i], d, m);
    end
    op(rd, wr, a, d, m, rdat, rdy, prd, pwr);
    chk(rdy == 1'b1, {tag, " R2 ready"}, {31'd0, rdy}, 32'd1);
    chk(rdat == exp, is_w ? {tag, " R8 write ack data"} : {tag, " R3 read data"}, rdat, exp);
    chk(prd == (!is_w && a[15:14] == 2'd2) && pwr == (is_w && a[15:14] == 2'd2),
        {tag, " R7 strobes"}, {30'd0, prd, pwr},
        {30'd0, (!is_w && a[15:14] == 2'd2), (is_w && a[15:14] == 2'd2)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rdat;
    bit rdy, prd, pwr;
    void'($urandom(32'd2024));

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0 && cpu_rdata == '0, "R10 in reset", cpu_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b0 && cpu_rdata == '0, "R10 after reset", {31'd0, cpu_ready}, 32'd0);

    // Fill both RAMs with known words (R1 separate storage)
    for (int k = 0; k < 1024; k++) begin
      mdl_lo[k] = $urandom;
      mdl_hi[k] = $urandom;
      op(1'b0, 1'b1, 16'(k * 4), mdl_lo[k], 4'hF, rdat, rdy, prd, pwr);
      op(1'b0, 1'b1, 16'h C000 + 16'(k * 4), mdl_hi[k], 4'hF, rdat, rdy, prd, pwr);
    end
    run(1'b1, 1'b0, 16'h0040, '0, 4'h0, "R1 low ram");
    run(1'b1, 1'b0, 16'hC040, '0, 4'h0, "R1 high ram");

    // R4: partial lane writes
    run(1'b0, 1'b1, 16'h0100, 32'h11223344, 4'hF, "R4 full");
    run(1'b0, 1'b1, 16'h0100, 32'hAABBCCDD, 4'b0101, "R4 lanes 0,2");
    run(1'b1, 1'b0, 16'h0100, '0, 4'h0, "R4 merged");
    run(1'b0, 1'b1, 16'hC104, 32'hDEADBEEF, 4'b1000, "R4 top lane");
    run(1'b1, 1'b0, 16'hC104, '0, 4'h0, "R4 top lane read");

    // R5: aliasing through bits [13:12] and [1:0]
    run(1'b0, 1'b1, 16'h0210, 32'hCAFEF00D, 4'hF, "R5 write");
    run(1'b1, 1'b0, 16'h3213, '0, 4'h0, "R5 alias read");
    run(1'b1, 1'b0, 16'hF211, '0, 4'h0, "R5 high ram not aliased to low");

    // R6: ROM content and write protection
    run(1'b1, 1'b0, 16'h4000, '0, 4'h0, "R6 rom first");
    run(1'b1, 1'b0, 16'h4FFC, '0, 4'h0, "R6 rom last");
    run(1'b0, 1'b1, 16'h4024, 32'h0BADCAFE, 4'hF, "R6 rom write");
    run(1'b1, 1'b0, 16'h7026, '0, 4'h0, "R6 rom after write");
    run(1'b1, 1'b0, 16'h0024, '0, 4'h0, "R6 low ram untouched");

    // R7: peripheral window
    run(1'b0, 1'b1, 16'h800C, 32'h00000006, 4'b0001, "R7 per write");
    run(1'b1, 1'b0, 16'hBFFC, '0, 4'h0, "R7 per read");

    // R9: both strobes act as a write
    run(1'b1, 1'b1, 16'h0300, 32'h5A5A5A5A, 4'hF, "R9 both");
    run(1'b1, 1'b1, 16'h8300, 32'h01020304, 4'h3, "R9 both per");
    run(1'b1, 1'b0, 16'h0300, '0, 4'h0, "R9 readback");

    // R2 / R8: idle cycle after a request
    run(1'b1, 1'b0, 16'h0300, '0, 4'h0, "R2 pre-idle");
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R2 idle ready", {31'd0, cpu_ready}, 32'd0);
    chk(cpu_rdata == '0, "R8 idle data", cpu_rdata, 32'd0);

    // Random mix
    for (int n = 0; n < 800; n++) begin
      logic [15:0] a;
      bit r, w;
      int kind;
      a = 16'($urandom);
      kind = $urandom % 5;
      r = (kind != 1);
      w = (kind == 1) || (kind == 4);
      run(r, w, a, $urandom, 4'($urandom), "RND R1 R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule